// File: doc/BRIEF.md
# Two-Wire Serial Slave Register Bank

This block is a slave on a two-wire serial bus (clock plus open-drain data, I2C-style) that gives a bus master access to a bank of 32 byte-wide control registers. Both bus lines are sampled with the system clock. The block detects start, repeated start and stop conditions and answers only to one fixed 7-bit device address. It never drives the clock line. It pulls the data line low through an output-enable and otherwise leaves it to the pull-up.

A write always carries three bytes: the device address with the direction bit clear, a register index, and one data byte. A read either returns the register chosen by the most recent index byte (current-address read), or sets the index first and then reverses direction with a repeated start (random read). Every transfer moves exactly one data byte and the index never advances by itself. Registers are writable or read-only according to a per-register mask parameter. All register contents are also presented in parallel to the surrounding logic.

Top module: `twi_regfile_slave`

## Requirements
- R1: After reset `sda_oe` is 0 and register i holds the value 0xA0 + i for every i in 0..31.
- R2: A device-address byte whose upper seven bits equal 0111110 is acknowledged by pulling the data line low during the ninth clock. Any other address gets no acknowledge, and the block leaves the line released and changes no register until the next start condition.
- R3: A write (address byte with bit 0 = 0, index byte, data byte, all MSB first) is acknowledged on all three bytes and stores the data byte in the indexed register when that register is writable.
- R4: With the default mask 0x7FFF_FFF0, registers 0 to 3 and 31 are read-only. A write to them is still acknowledged but leaves their value unchanged.
- R5: A random read (write-direction address, index byte, repeated start, address byte with bit 0 = 1) returns the indexed register, MSB first.
- R6: A current-address read returns the register chosen by the last index byte received. Neither reads nor writes advance that index.
- R7: Only one data byte moves per transfer. A byte after the write data byte is not acknowledged and changes nothing. After the read byte, the line stays released whether the master answers ACK or NACK, so further clocks read as 0xFF.
- R8: A stop or start condition aborts the transfer in progress from any state. A write cut short before its eighth data bit changes no register, and a start in mid-byte begins a fresh address phase.
- R9: `sda_oe` changes only while the bus clock is low.
- R10: Only the low five bits of the index byte select the register. The upper three bits are disregarded.
- R11: Byte i of `regs_flat` (bits 8i+7..8i) always shows the current content of register i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| regs_flat | output | 256 | All 32 registers side by side, register i in byte i |

## Verification
The bench writes and then random-reads every one of the 32 indices, so a mask decoded at the wrong bit either lets a read-only register change or blocks a writable one. It flips each of the seven address bits in turn; a decoder that ignores one bit would acknowledge or store under a neighbouring address. It reads at the current address twice in a row and after random reads, which exposes a pointer that auto-increments or is reloaded by a read. It also sends an extra byte after a write, clocks past the read byte, stops in the middle of a data byte and restarts in the middle of an address byte; a design that fails here acknowledges a burst, drives stale bits, commits half a byte, or stays stuck in an old phase.

// File: rtl/twi_pkg.sv
package twi_pkg;

  localparam logic [6:0] DEV_ADDR = 7'b0111110;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADEV,
    ST_REG,
    ST_AREG,
    ST_WDAT,
    ST_AWD,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } twi_st_e;

  // Device address byte: upper seven bits carry the address, bit 0 the direction.
  function automatic logic dev_match(logic [7:0] b);
    return b[7:1] == DEV_ADDR;
  endfunction

  // Power-up content of register idx.
  function automatic logic [7:0] init_val(int unsigned idx);
    return 8'hA0 ^ 8'(idx);
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_q     = scl_ff[STAGES-1];
  assign sda_q     = sda_ff[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/twi_proto_fsm.sv
module twi_proto_fsm
  import twi_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_q,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic [AW-1:0] ptr,
  output logic          wr_req,
  output logic [7:0]    wr_data,
  output twi_st_e       st
);
  logic [7:0] sh;
  logic [7:0] tx;
  logic [3:0] cnt;
  logic       rw;
  logic       byte_full;
  logic       rx_phase;

  assign byte_full = (cnt == 4'd8);
  assign rx_phase  = (st == ST_DEV) || (st == ST_REG) || (st == ST_WDAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sh      <= '0;
      tx      <= '0;
      cnt     <= '0;
      rw      <= 1'b0;
      sda_oe  <= 1'b0;
      ptr     <= '0;
      wr_req  <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_req <= 1'b0;
      if (start_det) begin
        st     <= ST_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (rx_phase) begin
        if (scl_rise && !byte_full) begin
          sh  <= {sh[6:0], sda_q};
          cnt <= cnt + 4'd1;
        end else if (scl_fall && byte_full) begin
          cnt <= '0;
          if (st == ST_DEV) begin
            if (dev_match(sh)) begin
              rw     <= sh[0];
              sda_oe <= 1'b1;
              st     <= ST_ADEV;
            end else begin
              st <= ST_SKIP;
            end
          end else if (st == ST_REG) begin
            ptr    <= sh[AW-1:0];
            sda_oe <= 1'b1;
            st     <= ST_AREG;
          end else begin
            wr_req  <= 1'b1;
            wr_data <= sh;
            sda_oe  <= 1'b1;
            st      <= ST_AWD;
          end
        end
      end else begin
        case (st)
          ST_ADEV: if (scl_fall) begin
            if (rw) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[7];
              st     <= ST_RDAT;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_REG;
            end
          end
          ST_AREG: if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= ST_WDAT;
          end
          ST_AWD: if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= ST_SKIP;
          end
          ST_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (byte_full) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                st     <= ST_RACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          ST_RACK: if (scl_fall) st <= ST_SKIP;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank
  import twi_pkg::*;
#(
  parameter int              NREG    = 32,
  parameter int              AW      = 5,
  parameter logic [NREG-1:0] WR_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] regs_flat
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (WR_MASK[i]) begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                q <= init_val(i);
        else if (wr_req && wr_addr == AW'(i))      q <= wr_data;
      end
      assign regs_flat[i*8 +: 8] = q;
    end else begin : g_ro
      assign regs_flat[i*8 +: 8] = init_val(i);
    end
  end

  assign rd_data = regs_flat[{rd_addr, 3'b000} +: 8];
endmodule

// File: rtl/twi_regfile_slave.sv
module twi_regfile_slave
  import twi_pkg::*;
#(
  parameter int              NREG    = 32,
  parameter logic [NREG-1:0] WR_MASK = 32'h7FFF_FFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_flat
);
  localparam int AW = $clog2(NREG);

  logic          scl_q;
  logic          sda_q;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_det;
  logic          stop_det;
  logic [AW-1:0] ptr;
  logic          wr_req;
  logic [7:0]    wr_data;
  logic [7:0]    rd_data;
  twi_st_e       st;

  twi_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_proto_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr), .wr_req(wr_req),
    .wr_data(wr_data), .st(st)
  );

  twi_reg_bank #(.NREG(NREG), .AW(AW), .WR_MASK(WR_MASK)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(ptr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data),
    .regs_flat(regs_flat)
  );
endmodule

// File: rtl/twi_regfile_chk.sv
module twi_regfile_chk
  import twi_pkg::*;
#(
  parameter int              NREG    = 32,
  parameter int              AW      = 5,
  parameter logic [NREG-1:0] WR_MASK = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_q,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe,
  input logic [AW-1:0]     ptr,
  input logic              wr_req,
  input logic [7:0]        wr_data,
  input logic [NREG*8-1:0] regs_flat,
  input twi_st_e           st
);
  logic [NREG*8-1:0] ro_bits;
  always_comb begin
    for (int i = 0; i < NREG; i++) ro_bits[i*8 +: 8] = WR_MASK[i] ? 8'h00 : 8'hFF;
  end

  logic          wv_q;
  logic [AW-1:0] wa_q;
  logic [7:0]    wd_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wv_q <= 1'b0;
      wa_q <= '0;
      wd_q <= '0;
    end else begin
      wv_q <= wr_req && WR_MASK[ptr];
      wa_q <= ptr;
      wd_q <= wr_data;
    end
  end

  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) && !$past(start_det || stop_det) |-> !$past(scl_q));

  p_skip_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> !sda_oe);

  p_ro_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(regs_flat & ro_bits));

  p_wr_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wv_q |-> (regs_flat[{wa_q, 3'b000} +: 8] == wd_q));

  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> ($past(st) == ST_REG));

  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && !start_det |=> (st == ST_IDLE) && !sda_oe);

  p_single_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);
endmodule

bind twi_regfile_slave twi_regfile_chk #(.NREG(NREG), .AW(AW), .WR_MASK(WR_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .ptr(ptr), .wr_req(wr_req),
  .wr_data(wr_data), .regs_flat(regs_flat), .st(st)
);

// File: tb/tb_twi_regfile_slave.sv
module tb_twi_regfile_slave;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'b0111110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [255:0] regs_flat;
  wire  sda_line = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  twi_regfile_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_flat(regs_flat)
  );

  int total = 0;
  int bad = 0;
  int viol = 0;
  bit done = 1'b0;
  logic [7:0] model [32];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit can_wr(int i);
    return (i >= 4) && (i <= 30);
  endfunction

  // R9 monitor: the slave must not move the data line while the clock is high
  logic oe_prev = 1'b0;
  always @(posedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && m_scl) viol++;
    oe_prev <= sda_oe;
  end

  task automatic wait_q(int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_q(1);
    m_scl = 1'b1; wait_q(1);
    m_sda = 1'b0; wait_q(1);
    m_scl = 1'b0; wait_q(1);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_q(1);
    m_scl = 1'b1; wait_q(1);
    m_sda = 1'b1; wait_q(1);
  endtask

  task automatic send_bit(logic b);
    m_sda = b; wait_q(1);
    m_scl = 1'b1; wait_q(2);
    m_scl = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wait_q(1);
    m_scl = 1'b1; wait_q(1);
    ack = ~sda_line; wait_q(1);
    m_scl = 1'b0; wait_q(1);
  endtask

  task automatic recv_byte(logic master_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q(1);
      m_scl = 1'b1; wait_q(1);
      b[i] = sda_line; wait_q(1);
      m_scl = 1'b0;
    end
    send_bit(~master_ack);
    m_sda = 1'b1; wait_q(1);
  endtask

  task automatic do_write(logic [6:0] dv, logic [7:0] idx, logic [7:0] d, output logic [2:0] acks);
    bus_start();
    send_byte({dv, 1'b0}, acks[2]);
    send_byte(idx, acks[1]);
    send_byte(d, acks[0]);
    bus_stop();
  endtask

  task automatic do_rand_read(logic [7:0] idx, output logic [7:0] d, output logic [2:0] acks);
    bus_start();
    send_byte({DEV, 1'b0}, acks[2]);
    send_byte(idx, acks[1]);
    bus_start();
    send_byte({DEV, 1'b1}, acks[0]);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic do_cur_read(output logic [7:0] d, output logic ack);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic       a;
    logic [7:0] d;
    logic [7:0] d2;
    logic [255:0] snap;

    for (int i = 0; i < 32; i++) model[i] = 8'hA0 + 8'(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R11: reset content and idle line
    chk("R1 sda_oe after reset", {31'd0, sda_oe}, 32'd0);
    for (int i = 0; i < 32; i++) chk("R1 R11 reset value", {24'd0, regs_flat[i*8 +: 8]}, {24'd0, model[i]});

    // R3 / R4 / R5 sweep over every index
    for (int i = 0; i < 32; i++) begin
      d = 8'(i * 37 + 11);
      do_write(DEV, 8'(i), d, acks);
      chk("R3 R4 write acks", {29'd0, acks}, 32'd7);
      if (can_wr(i)) model[i] = d;
      chk("R3 R4 R11 stored byte", {24'd0, regs_flat[i*8 +: 8]}, {24'd0, model[i]});
      do_rand_read(8'(i), d2, acks);
      chk("R5 random read acks", {29'd0, acks}, 32'd7);
      chk("R5 random read data", {24'd0, d2}, {24'd0, model[i]});
    end

    // R6: current-address reads follow the last index and do not advance
    do_write(DEV, 8'd12, 8'h5A, acks);
    model[12] = 8'h5A;
    do_cur_read(d, a);
    chk("R6 current read ack", {31'd0, a}, 32'd1);
    chk("R6 current read after write", {24'd0, d}, {24'd0, model[12]});
    do_cur_read(d, a);
    chk("R6 current read repeated", {24'd0, d}, {24'd0, model[12]});
    do_rand_read(8'd7, d, acks);
    do_cur_read(d, a);
    chk("R6 current read after random read", {24'd0, d}, {24'd0, model[7]});

    // R10: upper index bits disregarded
    do_write(DEV, 8'h25, 8'h99, acks);
    model[5] = 8'h99;
    chk("R10 index 0x25 hits register 5", {24'd0, regs_flat[5*8 +: 8]}, 32'h99);
    do_cur_read(d, a);
    chk("R10 pointer holds low bits", {24'd0, d}, 32'h99);

    // R2: every single-bit address error is ignored
    for (int k = 0; k < 7; k++) begin
      snap = regs_flat;
      do_write(DEV ^ 7'(1 << k), 8'd10, 8'h3C, acks);
      chk("R2 wrong address gets no ack", {29'd0, acks}, 32'd0);
      chk("R2 wrong address leaves bank", {31'd0, regs_flat == snap}, 32'd1);
      bus_start();
      send_byte({DEV ^ 7'(1 << k), 1'b1}, a);
      recv_byte(1'b0, d);
      bus_stop();
      chk("R2 wrong address read no ack", {31'd0, a}, 32'd0);
      chk("R2 wrong address read line idle", {24'd0, d}, 32'hFF);
    end

    // R7: extra byte after a write is refused and changes nothing
    snap = regs_flat;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'd8, a);
    send_byte(8'h11, a);
    chk("R7 data byte ack", {31'd0, a}, 32'd1);
    send_byte(8'h22, a);
    bus_stop();
    model[8] = 8'h11;
    chk("R7 extra write byte not acked", {31'd0, a}, 32'd0);
    chk("R7 register 8 keeps first byte", {24'd0, regs_flat[8*8 +: 8]}, 32'h11);
    chk("R7 register 9 untouched", {24'd0, regs_flat[9*8 +: 8]}, {24'd0, model[9]});

    // R7: after the read byte with master ACK the line stays released
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b1, d);
    recv_byte(1'b0, d2);
    bus_stop();
    chk("R7 read byte", {24'd0, d}, {24'd0, model[8]});
    chk("R7 second read byte idle", {24'd0, d2}, 32'hFF);

    // R8: stop in mid data byte commits nothing
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'd20, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    chk("R8 aborted write leaves register", {24'd0, regs_flat[20*8 +: 8]}, {24'd0, model[20]});

    // R8: start in mid address byte restarts the address phase
    bus_start();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte({DEV, 1'b0}, acks[2]);
    send_byte(8'd21, acks[1]);
    send_byte(8'hC3, acks[0]);
    bus_stop();
    model[21] = 8'hC3;
    chk("R8 restart acks", {29'd0, acks}, 32'd7);
    chk("R8 restart write lands", {24'd0, regs_flat[21*8 +: 8]}, 32'hC3);

    // R11: whole parallel bus matches the model
    for (int i = 0; i < 32; i++) chk("R11 parallel byte", {24'd0, regs_flat[i*8 +: 8]}, {24'd0, model[i]});

    chk("R9 data line moved while clock high", viol, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule